// File: doc/BRIEF.md
# PWM Generator with Dual-Stage Prescaler

This block drives one pulse-width-modulated output from a source clock. Counting is slowed by a prescaler with two stages. The first stage can divide by a fixed 1625, or it can be bypassed. The second stage divides by a power of two chosen by a 3-bit shift field. Because the two stages chain, one 13-bit period counter can cover periods from a single source cycle up to very slow rates, such as a blinking indicator.

Software sets the block up through a simple write port that holds three registers: control, period width and duty threshold. Width and threshold pass through shadow copies, which load only when a period ends. A rewrite while the output runs therefore never produces a clipped or stretched pulse. Clearing the enable bit forces the output low and returns every counter to zero.

Top module: `pwm_dual_prescaler`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pwm_o` is 0. After reset all three registers hold 0, so the block stays disabled and `pwm_o` stays 0.
- R2: A write with `wr_en` high lands at the rising edge. Address 0 is control: bit 15 enable, bit 3 long-divide select, bits [2:0] shift. Address 1 is the 13-bit width from `wr_data[12:0]`. Address 2 is the 13-bit threshold from `wr_data[12:0]`. A write to address 3 changes nothing.
- R3: With bit 3 clear, the counter steps once every 2^shift source cycles. It runs from 0 through the width W and then returns to 0, so one output period lasts (W+1)·2^shift cycles.
- R4: With bit 3 set, each step takes 1625·2^shift source cycles, and the output period is (W+1)·1625·2^shift cycles.
- R5: `pwm_o` is high while the count is below the threshold T, giving min(T, W+1) high steps per period. T = 0 holds the output low, and T > W holds it high.
- R6: New width and threshold values written while enabled take effect only when the counter wraps from W to 0. Until then the current period keeps the old values.
- R7: When enable is clear, `pwm_o` is 0 from the second edge after the write on, and the counters stay at zero. After enable is written, `pwm_o` shows count 0 one edge later, so a period starts with its high phase.
- R8: The largest settings work: shift 7 and a width of 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 width, 2 threshold) |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The hardest case to reach is a threshold rewrite that arrives partway through a period. The old and new thresholds disagree only for the rest of that period, so the check has to sample in exactly those cycles. The bench enables the block from a known zero count with a divide of one. Counting edges from the enable write, it puts the rewrite at a chosen count where the old threshold keeps the output high and the new one would pull it low. It then samples that cycle and the first steps of the next period. The long-divide paths are reached with small widths, so that a period of 6500 cycles can be measured twice within the run.

// File: rtl/pwm_dp_pkg.sv
package pwm_dp_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_WIDTH = 2'd1,
    REG_THRES = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/pwm_dp_regs.sv
module pwm_dp_regs #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 13,
  parameter int SHIFT_W  = 3,
  parameter int EN_BIT   = 15,
  parameter int LONG_BIT = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 en_o,
  output logic                 long_o,
  output logic [SHIFT_W-1:0]   shift_o,
  output logic [CNT_W-1:0]     width_o,
  output logic [CNT_W-1:0]     thres_o
);
  import pwm_dp_pkg::*;

  logic unused_data;
  assign unused_data = ^wr_data;

  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= 1'b0;
      long_o  <= 1'b0;
      shift_o <= '0;
      width_o <= '0;
      thres_o <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_CTRL: begin
          en_o    <= wr_data[EN_BIT];
          long_o  <= wr_data[LONG_BIT];
          shift_o <= wr_data[SHIFT_W-1:0];
        end
        REG_WIDTH: width_o <= wr_data[CNT_W-1:0];
        REG_THRES: thres_o <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pwm_dp_fixdiv.sv
module pwm_dp_fixdiv #(
  parameter int FIX_DIV = 1625
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic long_i,
  output logic tick_o
);
  localparam int FW = $clog2(FIX_DIV);
  localparam logic [FW-1:0] LAST = FW'(FIX_DIV - 1);

  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i || !long_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!en_i)       tick_o = 1'b0;
    else if (long_i) tick_o = (cnt_q == LAST);
    else             tick_o = 1'b1;
  end

endmodule

// File: rtl/pwm_dp_pow2div.sv
module pwm_dp_pow2div #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  localparam int PW = (1 << SHIFT_W) - 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      mask[i] = (i < int'(shift_i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_i && ((cnt_q & mask) == mask);

endmodule

// File: rtl/pwm_dp_core.sv
module pwm_dp_core #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] thres_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_width_o,
  output logic [CNT_W-1:0] act_thres_o,
  output logic             wrap_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, wid_q, thr_q;

  assign wrap_o = tick_i && (cnt_q == wid_q);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
      wid_q <= width_i;
      thr_q <= thres_i;
    end else if (wrap_o) begin
      cnt_q <= '0;
      wid_q <= width_i;
      thr_q <= thres_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= en_i && (cnt_q < thr_q);
  end

  assign cnt_o       = cnt_q;
  assign act_width_o = wid_q;
  assign act_thres_o = thr_q;

endmodule

// File: rtl/pwm_dual_prescaler.sv
module pwm_dual_prescaler #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 13,
  parameter int SHIFT_W  = 3,
  parameter int FIX_DIV  = 1625,
  parameter int EN_BIT   = 15,
  parameter int LONG_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_o
);
  logic               en_w, long_w, fix_tick_w, core_tick_w, wrap_w;
  logic [SHIFT_W-1:0] shift_w;
  logic [CNT_W-1:0]   width_w, thres_w, cnt_w, act_width_w, act_thres_w;

  pwm_dp_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W),
    .EN_BIT(EN_BIT), .LONG_BIT(LONG_BIT)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_o(en_w), .long_o(long_w), .shift_o(shift_w),
    .width_o(width_w), .thres_o(thres_w)
  );

  pwm_dp_fixdiv #(.FIX_DIV(FIX_DIV)) fix_i (
    .clk(clk), .rst(rst), .en_i(en_w), .long_i(long_w), .tick_o(fix_tick_w)
  );

  pwm_dp_pow2div #(.SHIFT_W(SHIFT_W)) pow_i (
    .clk(clk), .rst(rst), .en_i(en_w), .tick_i(fix_tick_w),
    .shift_i(shift_w), .tick_o(core_tick_w)
  );

  pwm_dp_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .en_i(en_w), .tick_i(core_tick_w),
    .width_i(width_w), .thres_i(thres_w),
    .cnt_o(cnt_w), .act_width_o(act_width_w), .act_thres_o(act_thres_w),
    .wrap_o(wrap_w), .pwm_o(pwm_o)
  );

endmodule

// File: rtl/pwm_dp_chk.sv
module pwm_dp_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             long_div,
  input logic             fix_tick,
  input logic             core_tick,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_width,
  input logic [CNT_W-1:0] act_thres,
  input logic             pwm_o
);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!pwm_o && cnt == '0));

  // R7
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_o);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && core_tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= act_width));

  // R4
  long_tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && long_div && fix_tick) |=> !fix_tick);

  // R5
  zero_thres_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en && act_thres == '0) |=> !pwm_o);

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> ($stable(act_width) && $stable(act_thres)));

endmodule

bind pwm_dual_prescaler pwm_dp_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .en(en_w), .long_div(long_w), .fix_tick(fix_tick_w),
  .core_tick(core_tick_w), .wrap(wrap_w), .cnt(cnt_w),
  .act_width(act_width_w), .act_thres(act_thres_w), .pwm_o(pwm_o)
);

// File: tb/pwm_dual_prescaler_tb.sv
`timescale 1ns/1ps
module pwm_dual_prescaler_tb_top;

  typedef struct packed {
    logic        lng;
    logic [2:0]  k;
    logic [12:0] w;
    logic [12:0] t;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 13'd9,    13'd3},    // R3 R5 basic
    '{1'b0, 3'd0, 13'd9,    13'd0},    // R5 constant low
    '{1'b0, 3'd0, 13'd9,    13'd10},   // R5 constant high
    '{1'b0, 3'd0, 13'd9,    13'd9},    // R5 one low step
    '{1'b0, 3'd2, 13'd5,    13'd2},    // R3 shift 2
    '{1'b0, 3'd7, 13'd1,    13'd1},    // R8 max shift
    '{1'b1, 3'd0, 13'd3,    13'd2},    // R4 long divide
    '{1'b1, 3'd1, 13'd1,    13'd1},    // R4 long divide with shift
    '{1'b0, 3'd0, 13'd8191, 13'd4096}, // R8 max width
    '{1'b0, 3'd3, 13'd0,    13'd1}     // R5 zero width
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_prescaler dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands at the next posedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'd0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(pwm_o == 1'b0, "R1 in reset", pwm_o, 0);
    rst = 1'b0;
    begin
      int highs = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pwm_o) highs++;
      end
      check(highs == 0, "R1 idle after reset", highs, 0);
    end

    // R3 R4 R5 R8 vector table
    for (int v = 0; v < NV; v++) begin
      longint d, p, hi, hcnt, rises;
      logic prev;
      d  = (longint'(1) << VECS[v].k) * (VECS[v].lng ? 1625 : 1);
      p  = (longint'(VECS[v].w) + 1) * d;
      hi = ((VECS[v].t > VECS[v].w) ? (longint'(VECS[v].w) + 1) : longint'(VECS[v].t)) * d;
      wr(2'd0, 16'h0000);
      wr(2'd1, {3'b000, VECS[v].w});
      wr(2'd2, {3'b000, VECS[v].t});
      wr(2'd0, 16'h8000 | (16'(VECS[v].lng) << 3) | 16'(VECS[v].k));
      for (longint i = 0; i < p; i++) @(negedge clk);
      hcnt = 0; rises = 0; prev = pwm_o;
      for (longint i = 0; i < 2 * p; i++) begin
        @(negedge clk);
        if (pwm_o) hcnt++;
        if (pwm_o && !prev) rises++;
        prev = pwm_o;
      end
      check(hcnt == 2 * hi, "R5 high cycles", hcnt, 2 * hi);
      check(rises == (((VECS[v].t == 0) || (VECS[v].t > VECS[v].w)) ? 0 : 2),
            VECS[v].lng ? "R4 period edges" : "R3 period edges",
            rises, ((VECS[v].t == 0) || (VECS[v].t > VECS[v].w)) ? 0 : 2);
    end

    // R2: address 3 write has no effect on a constant-high setup
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd10);
    wr(2'd0, 16'h8000);
    repeat (3) @(negedge clk);
    wr(2'd3, 16'h0000);
    begin
      int lows = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (!pwm_o) lows++;
      end
      check(lows == 0, "R2 address 3 ignored", lows, 0);
    end

    // R7: disable forces low
    wr(2'd0, 16'h0000);
    @(negedge clk);
    check(pwm_o == 1'b0, "R7 low after disable", pwm_o, 0);
    repeat (5) @(negedge clk);
    check(pwm_o == 1'b0, "R7 stays low", pwm_o, 0);

    // R7: restart from count zero, W=9 T=3 divide 1
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h8000);
    begin
      logic [3:0] seen;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        seen[i] = pwm_o;
      end
      check(seen == 4'b0111, "R7 restart pattern", seen, 4'b0111);
    end

    // R6: threshold rewrite mid-period, W=9 T=5 -> T=2
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h8000);
    repeat (3) @(negedge clk);
    wr(2'd2, 16'd2);
    @(negedge clk);
    check(pwm_o == 1'b1, "R6 old threshold kept", pwm_o, 1);
    repeat (5) @(negedge clk);
    check(pwm_o == 1'b0, "R6 last step of old period", pwm_o, 0);
    @(negedge clk);
    check(pwm_o == 1'b1, "R6 new period step 0", pwm_o, 1);
    @(negedge clk);
    check(pwm_o == 1'b1, "R6 new period step 1", pwm_o, 1);
    @(negedge clk);
    check(pwm_o == 1'b0, "R6 new threshold applied", pwm_o, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule